// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Interface

This block is the digital control logic for a two-channel 10-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial link: an active-low select/load line, a serial clock and a data line. The three pins are sampled in the system clock domain. Each word carries a 4-bit control code and a 10-bit data code. The code is executed when the select line returns high.

Each channel has two registers. The staging register takes new data codes. The output register drives the converter. Staging registers load one at a time or both at once. The output registers are always refreshed as a pair. A sleep flag, used to put the analog outputs in high impedance, is set by one code and cleared by any code that wakes the device. Register contents are kept while asleep, and the staging registers can still be loaded during sleep.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame is 16 bits. One bit is captured from `sdi` on each rising edge of `sclk` while `cs_n` is low. Bits 15..12 (sent first, MSB first) form the control code, bits 11..2 the data code (MSB first), and bits 1..0 are ignored.
- R2: A frame executes only when `cs_n` goes high. `sclk` edges seen while `cs_n` is high capture nothing and change no output. Outputs reflect a command no later than 10 clock cycles after `cs_n` rises.
- R3: If `cs_n` rises after any number of captured bits other than 16 (fewer or more), the frame is discarded and no state changes.
- R4: `dac_a` and `dac_b` show the output registers. They change only on an update command. Codes 0001 (load staging A) and 0010 (load staging B) leave both outputs unchanged.
- R5: An update copies both staging registers into both output registers in the same cycle. A staging register loaded by the same command contributes its newly loaded value.
- R6: Code 1110 sets `sleep` to 1. Its data field is ignored and every register keeps its value.
- R7: Codes 0001 and 0010 load staging registers while asleep, and `sleep` stays 1.
- R8: Wake-and-update codes clear `sleep` and update both outputs: 1000 (no load), 1001 (load A), 0101 (load B), 1111 (load both with the data code).
- R9: Codes 0011 (load A), 0100 (load B) and 1010 (load both) update both outputs and leave `sleep` unchanged.
- R10: Codes 0000, 0110, 0111, 1011, 1100 and 1101 change no register.
- R11: While `rst` is high, all four registers read zero and `sleep` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low select; its rising edge executes the frame |
| dac_a | output | 10 | Channel A output register |
| dac_b | output | 10 | Channel B output register |
| sleep | output | 1 | High while the device is asleep |

## Verification
The bench builds the block with its default parameters: a 10-bit data code, a 4-bit control code, two padding bits and a two-stage input synchronizer. This is the 16-bit frame that all requirements describe. Serial half-periods of four system clocks let the synchronized edge detector see every `sclk` transition, so the bit-count boundaries of 15, 16 and 17 can be reached exactly. Random frames of 12 to 20 bits, with random codes, exercise every decoded code in both the awake and asleep states. The staging registers are checked indirectly, through the output values after each later update.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   typedef struct packed {
      logic ld_a;
      logic ld_b;
      logic upd;
      logic wake;
      logic sleep;
   } dacif_act_t;

   function automatic dacif_act_t dacif_decode(input logic [3:0] code);
      dacif_act_t a;
      a = '0;
      case (code)
         4'b0001: a.ld_a = 1'b1;
         4'b0010: a.ld_b = 1'b1;
         4'b0011: begin a.ld_a = 1'b1; a.upd = 1'b1; end
         4'b0100: begin a.ld_b = 1'b1; a.upd = 1'b1; end
         4'b0101: begin a.ld_b = 1'b1; a.upd = 1'b1; a.wake = 1'b1; end
         4'b1000: begin a.upd = 1'b1; a.wake = 1'b1; end
         4'b1001: begin a.ld_a = 1'b1; a.upd = 1'b1; a.wake = 1'b1; end
         4'b1010: begin a.ld_a = 1'b1; a.ld_b = 1'b1; a.upd = 1'b1; end
         4'b1110: a.sleep = 1'b1;
         4'b1111: begin a.ld_a = 1'b1; a.ld_b = 1'b1; a.upd = 1'b1; a.wake = 1'b1; end
         default: a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("dacif_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/dacif_serial_rx.sv
module dacif_serial_rx #(
   parameter int DATA_W      = 10,
   parameter int CODE_W      = 4,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              cs_n,
   output logic              cmd_valid,
   output logic [CODE_W-1:0] cmd_code,
   output logic [DATA_W-1:0] cmd_data
);

   localparam int FRAME_W = CODE_W + DATA_W + PAD_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   if (DATA_W < 1 || CODE_W < 1 || PAD_W < 0 || SYNC_STAGES < 0) begin : g_bad_par
      $error("dacif_serial_rx: illegal field widths");
   end

   logic [2:0] pins_s;
   logic       s_sclk, s_sdi, s_csn;
   logic       prev_sclk, prev_csn;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;
   logic       sclk_rise, cs_rise;

   dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({cs_n, sclk, sdi}),
      .q   (pins_s)
   );

   assign s_csn  = pins_s[2];
   assign s_sclk = pins_s[1];
   assign s_sdi  = pins_s[0];

   assign sclk_rise = s_sclk & ~prev_sclk;
   assign cs_rise   = s_csn & ~prev_csn;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_sclk <= 1'b0;
         prev_csn  <= 1'b1;
         shreg     <= '0;
         cnt       <= '0;
         cmd_valid <= 1'b0;
      end else begin
         prev_sclk <= s_sclk;
         prev_csn  <= s_csn;
         cmd_valid <= cs_rise && (cnt == CNT_FULL);
         if (s_csn) begin
            cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], s_sdi};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
         end
      end
   end

   assign cmd_code = shreg[FRAME_W-1 -: CODE_W];
   assign cmd_data = shreg[PAD_W +: DATA_W];

   // R2: a command is a single-cycle pulse, one per select rise
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |=> !cmd_valid);

   // R3: only a frame of exactly FRAME_W captured bits may execute
   a_r3_full_frame: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> $past(cnt) == CNT_FULL);

   // R2: the shift register is frozen while select is high
   a_r2_idle_frozen: assert property (@(posedge clk) disable iff (rst)
      $past(s_csn) |-> $stable(shreg));

endmodule

// File: rtl/dacif_regbank.sv
module dacif_regbank
   import dacif_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  dacif_act_t        act,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] dac_a,
   output logic [DATA_W-1:0] dac_b,
   output logic              asleep
);

   logic [DATA_W-1:0] in_a, in_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_a   <= '0;
         in_b   <= '0;
         dac_a  <= '0;
         dac_b  <= '0;
         asleep <= 1'b0;
      end else if (cmd_valid) begin
         if (act.ld_a) in_a <= data;
         if (act.ld_b) in_b <= data;
         if (act.upd) begin
            dac_a <= act.ld_a ? data : in_a;
            dac_b <= act.ld_b ? data : in_b;
         end
         if (act.sleep)     asleep <= 1'b1;
         else if (act.wake) asleep <= 1'b0;
      end
   end

   // R4: outputs hold unless a command arrived the cycle before
   a_r4_dac_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(cmd_valid) |-> ($stable(dac_a) && $stable(dac_b)));

   // R6: sleep entry only through an executed command
   a_r6_sleep_entry: assert property (@(posedge clk) disable iff (rst)
      $rose(asleep) |-> $past(cmd_valid));

   // R8: wake only through an executed command
   a_r8_wake_cmd: assert property (@(posedge clk) disable iff (rst)
      $fell(asleep) |-> $past(cmd_valid));

   // R6: staging registers are untouched by the sleep command
   a_r6_keep_stage: assert property (@(posedge clk) disable iff (rst)
      ($past(cmd_valid) && $past(act.sleep)) |-> ($stable(in_a) && $stable(in_b)));

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
   import dacif_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              cs_n,
   output logic [DATA_W-1:0] dac_a,
   output logic [DATA_W-1:0] dac_b,
   output logic              sleep
);

   localparam int CODE_W = 4;

   logic              cmd_valid;
   logic [CODE_W-1:0] cmd_code;
   logic [DATA_W-1:0] cmd_data;
   dacif_act_t        act;

   dacif_serial_rx #(
      .DATA_W(DATA_W), .CODE_W(CODE_W), .PAD_W(PAD_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_rx (
      .clk       (clk),
      .rst       (rst),
      .sclk      (sclk),
      .sdi       (sdi),
      .cs_n      (cs_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_data  (cmd_data)
   );

   assign act = dacif_decode(cmd_code);

   dacif_regbank #(.DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .act       (act),
      .data      (cmd_data),
      .dac_a     (dac_a),
      .dac_b     (dac_b),
      .asleep    (sleep)
   );

   // R11: reset leaves the block awake with zero outputs
   a_r11_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (dac_a == '0 && dac_b == '0 && !sleep));

endmodule

// File: tb/dual_dac_ctrl_bench.sv
module dual_dac_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       cs_n = 1'b1;
   logic [9:0] dac_a, dac_b;
   logic       sleep;

   int total = 0;
   int bad   = 0;

   logic [9:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;
   logic       m_sleep = 1'b0;

   always #5 clk = ~clk;

   dual_dac_ctrl u_dual_dac_ctrl (
      .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
      .dac_a(dac_a), .dac_b(dac_b), .sleep(sleep)
   );

   // {ld_a, ld_b, upd, wake, sleep}
   function automatic logic [4:0] exp_act(input logic [3:0] c);
      case (c)
         4'h1: return 5'b10000;
         4'h2: return 5'b01000;
         4'h3: return 5'b10100;
         4'h4: return 5'b01100;
         4'h5: return 5'b01110;
         4'h8: return 5'b00110;
         4'h9: return 5'b10110;
         4'hA: return 5'b11100;
         4'hE: return 5'b00001;
         4'hF: return 5'b11110;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic model_apply(input logic [3:0] c, input logic [9:0] d);
      logic [4:0] a;
      a = exp_act(c);
      if (a[4]) m_in_a = d;
      if (a[3]) m_in_b = d;
      if (a[2]) begin m_dac_a = m_in_a; m_dac_b = m_in_b; end
      if (a[0]) m_sleep = 1'b1;
      else if (a[1]) m_sleep = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " dac_a"}, dac_a, m_dac_a);
      chk({tag, " dac_b"}, dac_b, m_dac_b);
      chk({tag, " sleep"}, {9'd0, sleep}, {9'd0, m_sleep});
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [3:0] c, input logic [9:0] d, input int nbits);
      logic [15:0] w;
      w = {c, d, 2'($urandom)};
      @(negedge clk);
      sclk = 1'b0;
      cs_n = 1'b0;
      wclk(4);
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 16) ? w[15-i] : 1'($urandom);
         wclk(4);
         sclk = 1'b1;
         wclk(4);
         sclk = 1'b0;
      end
      wclk(2);
      cs_n = 1'b1;
      wclk(12);
      if (nbits == 16) model_apply(c, d);
   endtask

   task automatic idle_toggle(input int n);
      for (int i = 0; i < n; i++) begin
         sdi = 1'($urandom);
         wclk(4);
         sclk = 1'b1;
         wclk(4);
         sclk = 1'b0;
      end
      wclk(4);
   endtask

   initial begin
      void'($urandom(32'd4242));
      wclk(5);
      chk_all("R11 reset");
      rst = 1'b0;
      wclk(4);
      chk_all("R11 after reset");

      send(4'h1, 10'h155, 16); chk_all("R4 load A no output change");
      send(4'h2, 10'h2AA, 16); chk_all("R4 load B no output change");
      send(4'h8, 10'h000, 16); chk_all("R5 R8 wake-update pair");
      send(4'hE, 10'h3FF, 16); chk_all("R6 sleep keeps outputs");
      send(4'h1, 10'h0AB, 16); chk_all("R7 load A asleep");
      send(4'h5, 10'h321, 16); chk_all("R8 load B wake update");
      send(4'hF, 10'h111, 15); chk_all("R3 short frame dropped");
      send(4'hF, 10'h111, 17); chk_all("R3 long frame dropped");
      idle_toggle(20);         chk_all("R2 clocks while deselected");
      send(4'h3, 10'h3C0, 16); chk_all("R2 frame after idle clocks");
      send(4'hA, 10'h201, 16); chk_all("R1 bit order both channels");
      send(4'h6, 10'h0F0, 16); chk_all("R10 nop code");
      send(4'hE, 10'h000, 16);
      send(4'h4, 10'h07E, 16); chk_all("R9 update while asleep");
      send(4'h9, 10'h1C3, 16); chk_all("R8 load A wake update");

      for (int k = 0; k < 300; k++) begin
         int nb;
         nb = ($urandom % 5 == 0) ? 12 + int'($urandom % 9) : 16;
         send(4'($urandom), 10'($urandom), nb);
         chk_all("R5 R9 R10 random frame");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule